// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block carries out the power-down command of a small processor core. It watches the instruction word at the first phase of each four-phase instruction cycle. When that word is the sleep command, it does three things in a fixed order. In the third phase it clears the watchdog counter and its postscaler, raises the time-out flag and clears the power-down flag. At the close of the fourth phase it drops the core clock enable. The core then stays halted until a wake-up arrives.

The watchdog is a base counter followed by a postscaler. It runs on the always-on clock, so it keeps counting while the core is halted. A time-out while the core is halted is a wake-up: the clock enable comes back and the time-out flag is cleared. A time-out while the core is running gives a one-cycle reset pulse instead. An external wake request also restarts a halted core, but it leaves both flags as they are. Software reads the two flags to learn why the core woke.

The whole block runs on one always-on clock. The core clock enable it produces qualifies the phase strobes that pace the instruction cycle.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: While reset is asserted, and on release, the clock enable is 1, both flags are 1, the phase is Q1 (code 0) and both watchdog counters read 0.
- R2: The word 0x0003 is taken at a Q1 strobe. At the Q3 strobe that follows, `wdt_clr` is high for that one cycle, and both watchdog counters read 0 after the edge.
- R3: At that same Q3 strobe the time-out flag becomes 1 and the power-down flag becomes 0.
- R4: At the Q4 strobe of a sleep command the clock enable goes to 0 on that edge, and the phase returns to Q1.
- R5: Any other 16-bit word taken at Q1 leaves the clock enable and both flags unchanged and gives no `wdt_clr` pulse.
- R6: The phase (Q1..Q4 coded 0..3) advances by one on each `q_stb` while the clock enable is 1. While the clock enable is 0, strobes are ignored and the phase holds.
- R7: The base counter rises by one on every clock edge, whether the core is running or halted. When the base counter wraps, the postscaler rises by one. `wdt_timeout` is high for the single cycle in which both counters are at their maximum, so it recurs every 2^(CNT_W+POST_W) cycles.
- R8: A time-out while the clock enable is 0 sets the clock enable to 1 and the time-out flag to 0 on that edge. The power-down flag stays 0.
- R9: A wake request with no time-out while the clock enable is 0 sets the clock enable to 1 on that edge and leaves both flags unchanged.
- R10: A time-out while the clock enable is 1 drives `wdt_reset` high for that cycle and clears the time-out flag. The power-down flag and the clock enable are unchanged.
- R11: A wake request while the clock enable is 1 has no effect on the clock enable or on either flag.
- R12: When the sleep clear falls in the same cycle in which the counters would time out, the clear wins. No time-out pulse occurs and the counters restart from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | INSTR_W | Instruction word, sampled at a Q1 strobe |
| q_stb | input | 1 | Phase strobe; one pulse per phase |
| wake_req | input | 1 | External wake-up request |
| core_clk_en | output | 1 | Core clock enable |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| wdt_clr | output | 1 | Watchdog clear strobe, high for the Q3 cycle of a sleep command |
| wdt_timeout | output | 1 | Watchdog time-out pulse |
| wdt_reset | output | 1 | Reset pulse for a time-out while the core is running |
| wdt_count | output | CNT_W | Watchdog base counter value |
| wdt_post | output | POST_W | Watchdog postscaler value |
| q_phase | output | 2 | Current phase, 0..3 for Q1..Q4 |

## Verification
A stale pending-sleep bit or a wrong phase count moves the clear strobe or the clock gating to the wrong phase. The per-cycle phase and strobe comparison catches this within the same instruction cycle. A watchdog that misses a clear, or counts wrongly, shows at the ports within one edge through the counter values. A wrong wake-up decision or flag update shows in the enable and flag outputs on the edge after the time-out or wake request. The bench runs a reference model every cycle. It also sweeps all single-bit neighbours of the sleep word and sets up the case where a clear and a time-out fall in the same cycle.

// File: rtl/sleepctl_pkg.sv
package sleepctl_pkg;
  localparam logic [1:0] PH_Q1 = 2'd0;
  localparam logic [1:0] PH_Q2 = 2'd1;
  localparam logic [1:0] PH_Q3 = 2'd2;
  localparam logic [1:0] PH_Q4 = 2'd3;

  // True when the word is the power-down command.
  function automatic logic is_sleep_word(input logic [15:0] w);
    return w == 16'h0003;
  endfunction

  // Phase after one strobe: Q4 wraps to Q1.
  function automatic logic [1:0] phase_after(input logic [1:0] p);
    return p + 2'd1;
  endfunction
endpackage

// File: rtl/sc_phase_seq.sv
module sc_phase_seq
  import sleepctl_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               q_stb,
  input  logic [INSTR_W-1:0] instr_word,
  output logic [1:0]         phase,
  output logic               sleep_exec,
  output logic               sleep_enter
);
  logic advance;
  logic pend;

  assign advance     = q_stb & run;
  assign sleep_exec  = advance & pend & (phase == PH_Q3);
  assign sleep_enter = advance & pend & (phase == PH_Q4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_Q1;
      pend  <= 1'b0;
    end else if (advance) begin
      phase <= phase_after(phase);
      if (phase == PH_Q1)
        pend <= is_sleep_word(16'(instr_word));
      else if (phase == PH_Q4)
        pend <= 1'b0;
    end
  end

  // R6: the phase is frozen while the core clock is gated
  p_hold_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(phase));
  // R4: the core is gated only from Q4, so the next instruction starts at Q1
  p_enter_to_q1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> phase == PH_Q1);
endmodule

// File: rtl/sc_wdt.sv
module sc_wdt #(
  parameter int CNT_W  = 8,
  parameter int POST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  output logic [CNT_W-1:0]  count,
  output logic [POST_W-1:0] post,
  output logic              to_evt
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [POST_W-1:0] POST_MAX = '1;

  logic cnt_wrap;

  assign cnt_wrap = (count == CNT_MAX);
  assign to_evt   = cnt_wrap & (post == POST_MAX) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      post  <= '0;
    end else if (clr) begin
      count <= '0;
      post  <= '0;
    end else begin
      count <= count + 1'b1;
      if (cnt_wrap) post <= post + 1'b1;
    end
  end

  // R2: a clear leaves both counters at zero
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && (post == '0));
  // R7: the time-out is a single-cycle pulse and the counters restart
  p_timeout_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> !to_evt && (count == '0) && (post == '0));
  // R7: without a clear the base counter always steps by one
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/sc_status.sv
module sc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_exec,
  input  logic sleep_enter,
  input  logic to_evt,
  input  logic wake_req,
  output logic clk_en,
  output logic to_flag,
  output logic pd_flag,
  output logic wdt_reset
);
  logic wake_by_wdt;
  logic wake_by_ext;

  assign wake_by_wdt = to_evt & ~clk_en;
  assign wake_by_ext = wake_req & ~to_evt & ~clk_en;
  assign wdt_reset   = to_evt & clk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en  <= 1'b1;
      to_flag <= 1'b1;
      pd_flag <= 1'b1;
    end else begin
      if (sleep_enter)
        clk_en <= 1'b0;
      else if (wake_by_wdt || wake_by_ext)
        clk_en <= 1'b1;

      if (sleep_exec)
        to_flag <= 1'b1;
      else if (to_evt)
        to_flag <= 1'b0;

      if (sleep_exec)
        pd_flag <= 1'b0;
    end
  end

  // R3: the sleep execute phase sets TO and clears PD
  p_sleep_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_exec |=> to_flag && !pd_flag);
  // R4: entering sleep gates the core clock
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> !clk_en);
  // R8: a watchdog wake-up restarts the core with TO cleared
  p_wdt_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_by_wdt |=> clk_en && !to_flag && $stable(pd_flag));
  // R9: an external wake-up keeps both flags
  p_ext_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_by_ext |=> clk_en && $stable(to_flag) && $stable(pd_flag));
  // R10: a time-out while running clears TO and keeps PD and the clock
  p_awake_to_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> clk_en && !to_flag && $stable(pd_flag));
  // R11: a wake request while running changes nothing
  p_wake_awake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && clk_en && !sleep_enter && !sleep_exec && !to_evt)
      |=> clk_en && $stable(to_flag) && $stable(pd_flag));
endmodule

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl #(
  parameter int INSTR_W = 16,
  parameter int CNT_W   = 8,
  parameter int POST_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               q_stb,
  input  logic               wake_req,
  output logic               core_clk_en,
  output logic               to_flag,
  output logic               pd_flag,
  output logic               wdt_clr,
  output logic               wdt_timeout,
  output logic               wdt_reset,
  output logic [CNT_W-1:0]   wdt_count,
  output logic [POST_W-1:0]  wdt_post,
  output logic [1:0]         q_phase
);
  logic sleep_exec;
  logic sleep_enter;
  logic to_evt;

  sc_phase_seq #(.INSTR_W(INSTR_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (core_clk_en),
    .q_stb       (q_stb),
    .instr_word  (instr_word),
    .phase       (q_phase),
    .sleep_exec  (sleep_exec),
    .sleep_enter (sleep_enter)
  );

  sc_wdt #(.CNT_W(CNT_W), .POST_W(POST_W)) u_wdt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sleep_exec),
    .count  (wdt_count),
    .post   (wdt_post),
    .to_evt (to_evt)
  );

  sc_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_exec  (sleep_exec),
    .sleep_enter (sleep_enter),
    .to_evt      (to_evt),
    .wake_req    (wake_req),
    .clk_en      (core_clk_en),
    .to_flag     (to_flag),
    .pd_flag     (pd_flag),
    .wdt_reset   (wdt_reset)
  );

  assign wdt_clr     = sleep_exec;
  assign wdt_timeout = to_evt;

  // R12: a clear in the time-out cycle suppresses the pulse
  p_clr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> !wdt_timeout && !wdt_reset);
endmodule

// File: tb/test_sleep_wdt_ctrl.sv
module test_sleep_wdt_ctrl;
  localparam int CW  = 4;
  localparam int PW  = 2;
  localparam int PER = 1 << (CW + PW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   instr_word = '0;
  logic          q_stb = 1'b0;
  logic          wake_req = 1'b0;
  logic          core_clk_en, to_flag, pd_flag, wdt_clr, wdt_timeout, wdt_reset;
  logic [CW-1:0] wdt_count;
  logic [PW-1:0] wdt_post;
  logic [1:0]    q_phase;

  int n_chk = 0;
  int n_bad = 0;
  // reference model state
  int m_ph = 0, m_wd = 0;
  bit m_pend = 0, m_en = 1, m_to = 1, m_pd = 1;
  bit saw_rst = 0, r12_hit = 0, r12_tmo = 0;

  always #5 clk = ~clk;

  sleep_wdt_ctrl #(.INSTR_W(16), .CNT_W(CW), .POST_W(PW)) i_sleep_wdt_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .q_stb(q_stb),
    .wake_req(wake_req), .core_clk_en(core_clk_en), .to_flag(to_flag),
    .pd_flag(pd_flag), .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout),
    .wdt_reset(wdt_reset), .wdt_count(wdt_count), .wdt_post(wdt_post),
    .q_phase(q_phase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // One clock cycle: check pulses, step model, check registered outputs.
  task automatic cyc();
    bit adv, ex, ent, tmo;
    #1;
    adv = q_stb && m_en;
    ex  = adv && (m_ph == 2) && m_pend;
    ent = adv && (m_ph == 3) && m_pend;
    tmo = (m_wd == PER - 1) && !ex;
    if (ex && m_wd == PER - 1) begin r12_hit = 1; r12_tmo = wdt_timeout; end
    chk("R2 clear strobe", wdt_clr, ex);
    chk("R7 timeout pulse", wdt_timeout, tmo);
    chk("R10 reset pulse", wdt_reset, tmo && m_en);
    if (wdt_reset) saw_rst = 1;
    m_wd = ex ? 0 : (m_wd + 1) % PER;
    if (adv && m_ph == 0) m_pend = (instr_word == 16'h0003);
    else if (adv && m_ph == 3) m_pend = 0;
    if (adv) m_ph = (m_ph + 1) % 4;
    if (ent) m_en = 0;
    else if (!m_en && (tmo || wake_req)) m_en = 1;
    if (ex) m_to = 1; else if (tmo) m_to = 0;
    if (ex) m_pd = 0;
    @(posedge clk); #2;
    chk("R4/R8/R9 clock enable", core_clk_en, m_en);
    chk("R3/R8/R10 TO flag", to_flag, m_to);
    chk("R3 PD flag", pd_flag, m_pd);
    chk("R6 phase", q_phase, m_ph);
    chk("R7 base count", wdt_count, m_wd % (1 << CW));
    chk("R7 postscaler", wdt_post, m_wd / (1 << CW));
  endtask

  task automatic do_instr(input logic [15:0] w, input int gap);
    for (int k = 0; k < 4; k++) begin
      instr_word = w; q_stb = 1'b1; cyc();
      q_stb = 1'b0;
      for (int g = 0; g < gap; g++) cyc();
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    bit to_before, pd_before;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 clock enable", core_clk_en, 1);
    chk("R1 TO", to_flag, 1);
    chk("R1 PD", pd_flag, 1);
    chk("R1 phase", q_phase, 0);
    chk("R1 count", wdt_count, 0);
    chk("R1 post", wdt_post, 0);
    rst_n = 1'b1;

    // R5: all single-bit neighbours of the sleep word, plus zero
    do_instr(16'h0000, 0);
    for (int b = 0; b < 16; b++) begin
      bit clr_seen;
      clr_seen = 0;
      instr_word = 16'h0003 ^ (16'h1 << b);
      for (int k = 0; k < 4; k++) begin
        q_stb = 1'b1; #1; if (wdt_clr) clr_seen = 1; cyc();
      end
      q_stb = 1'b0;
      chk("R5 no clear for other word", clr_seen, 0);
      chk("R5 clock stays on", core_clk_en, 1);
    end
    // 68 cycles awake: one running time-out occurred (R10)
    chk("R10 TO cleared by running time-out", to_flag, 0);
    chk("R10 PD kept at 1", pd_flag, 1);
    chk("R10 reset pulse seen", saw_rst, 1);

    // Sleep, strobes while halted, external wake
    do_instr(16'h0003, 1);
    chk("R3 TO set", to_flag, 1);
    chk("R3 PD cleared", pd_flag, 0);
    chk("R4 clock gated", core_clk_en, 0);
    q_stb = 1'b1; repeat (3) cyc(); q_stb = 1'b0;
    chk("R6 phase held while halted", q_phase, 0);
    wake_req = 1'b1; cyc(); wake_req = 1'b0;
    chk("R9 clock back", core_clk_en, 1);
    chk("R9 TO kept", to_flag, 1);
    chk("R9 PD kept", pd_flag, 0);
    wake_req = 1'b1; repeat (3) cyc(); wake_req = 1'b0;
    chk("R11 enable unchanged", core_clk_en, 1);
    chk("R11 TO unchanged", to_flag, 1);
    chk("R11 PD unchanged", pd_flag, 0);

    // Sleep, then watchdog wake after a full period
    do_instr(16'h0003, 0);
    n = 0;
    while (!core_clk_en && n < 200) begin cyc(); n++; end
    chk("R8 halted cycles until wake", n, PER - 1);
    chk("R8 TO cleared", to_flag, 0);
    chk("R8 PD stays 0", pd_flag, 0);

    // Running time-out after a sleep with external wake
    do_instr(16'h0003, 0);
    wake_req = 1'b1; cyc(); wake_req = 1'b0;
    saw_rst = 0;
    to_before = to_flag; pd_before = pd_flag;
    chk("R9 TO before running time-out", to_before, 1);
    n = 0;
    while (!saw_rst && n < 200) begin cyc(); n++; end
    chk("R10 reset pulse", saw_rst, 1);
    chk("R10 TO cleared", to_flag, 0);
    chk("R10 PD unchanged", pd_flag, pd_before);
    chk("R10 clock stays on", core_clk_en, 1);

    // R12: Q3 of a sleep word lands on the time-out cycle
    while (m_wd != PER - 3) cyc();
    r12_hit = 0;
    instr_word = 16'h0003;
    q_stb = 1'b1; repeat (4) cyc(); q_stb = 1'b0;
    chk("R12 collision reached", r12_hit, 1);
    chk("R12 no time-out pulse", r12_tmo, 0);
    chk("R12 TO set", to_flag, 1);
    wake_req = 1'b1; cyc(); wake_req = 1'b0;
    repeat (8) cyc();

    summary();
    $finish;
  end
endmodule